// File: doc/BRIEF.md
# Multi-Mode Timer Channel With Pin Polarity Control

This block is one timer channel with a 24-bit up-counter and a single timer pin. The pin is split into an input, an output and an output enable, which the pad ring merges into one bidirectional pad. Software sets the channel up through a synchronous register port. It chooses a mode and then enables the channel. In the output modes the counter runs once per clock and the pin emits a pulse or toggles on each compare match. In the input modes the counter counts pin edges, or it measures the width of a pulse or the period between edges, and the result is stored in a capture register.

A single invert bit changes the pin's meaning everywhere. It selects which edge is counted, which pulse level is measured and which edges bound a period. It also inverts the level that is read back and the level that is driven. The pin input goes through a synchronizer before any edge is detected, so a level has to be held for at least two clocks to be seen. Compare/capture events and counter wrap-around each set a sticky flag. Writing 1 to a flag clears it. Each flag raises an interrupt line only when its enable bit is set.

Register map (word addresses): 0 = control, 1 = load value, 2 = compare value, 3 = status, 4 = counter (read only), 5 = capture (read only). Control register fields: bits [2:0] mode, bit 3 enable, bit 4 invert, bit 5 compare-interrupt enable, bit 6 overflow-interrupt enable, bit 7 GPIO direction (1 = drive), bit 8 GPIO output value. Status register fields: bit 0 compare/capture flag, bit 1 overflow flag, bit 2 synchronized pin level after inversion (read only). Any address that is not mapped reads as zero.

Top module: `mmtimer`

## Requirements
- R1: When a control write sets the enable bit while it is clear, the counter takes the load value on that clock edge. While the enable bit is clear, the counter holds its value.
- R2: A counted event with the counter at 0xFFFFFF and no compare match wraps the counter to 0 and sets status bit 1. irq_ovf is high only while that flag and the overflow-interrupt enable are both set.
- R3: In the counting modes, with load N and compare M (M >= N), the compare flag (status bit 0) sets on the (M-N+1)th counted event, and the counter reloads to N at the same time.
- R4: Mode 3 counts rising edges of the synchronized pin when invert = 0 and falling edges when invert = 1. The opposite edge leaves the counter unchanged.
- R5: Mode 4 measures the active pulse (high when invert = 0, low when invert = 1). When the pulse ends, the capture register becomes load + the number of clocks the pulse lasted, status bit 0 sets and the counter reloads.
- R6: Mode 5 measures from one active edge (rising when invert = 0, falling when invert = 1) to the next. On every active edge after the first, the capture register becomes load + the number of clocks between the two edges, and status bit 0 sets.
- R7: In GPIO mode, status bit 2 reads the synchronized pin XOR invert. With direction = 1, pin_oe is 1 and pin_out = GPIO value XOR invert.
- R8: In mode 1 (pulse) the internal output goes high for the one clock of a compare match. In mode 2 (toggle) it flips on each match and starts at 0 on enable. While either mode is enabled, pin_oe is 1 and pin_out = internal output XOR invert.
- R9: When the mode is 1 to 5 and the channel is disabled, and also in modes 3, 4 and 5, pin_oe is 0.
- R10: Writing 1 to a status flag bit clears that flag, and writing 0 leaves it unchanged. irq_cmp is high only while the compare flag and the compare-interrupt enable are both set.
- R11: Mode codes 6 and 7 behave exactly like mode 0 (GPIO).
- R12: After reset, every register and flag is 0, pin_oe is 0 and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 24 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 24 | Register read data (combinational) |
| pin_in | input | 1 | Timer pin input from the pad |
| pin_out | output | 1 | Timer pin output level |
| pin_oe | output | 1 | Timer pin output enable |
| irq_cmp | output | 1 | Compare/capture interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
The assertions check, on every clock, that the counter is loaded on start and frozen while disabled, and that a compare match reloads the counter and sets its flag. They also check that a wrap from all ones sets the overflow flag, that the end of a width pulse captures the running count, and that the pin driver is released in the disabled output modes. Only the bench scenarios can show end-to-end behaviour: that each invert setting picks the correct edge or level after the synchronizer, the exact capture values for given pulse widths and periods, the event count at which the interrupt fires, and the pin levels that software sees.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
   localparam logic [2:0] M_GPIO   = 3'd0;
   localparam logic [2:0] M_PULSE  = 3'd1;
   localparam logic [2:0] M_TOGGLE = 3'd2;
   localparam logic [2:0] M_EVENT  = 3'd3;
   localparam logic [2:0] M_WIDTH  = 3'd4;
   localparam logic [2:0] M_PERIOD = 3'd5;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_LOAD = 3'd1;
   localparam logic [2:0] A_CMP  = 3'd2;
   localparam logic [2:0] A_STAT = 3'd3;
   localparam logic [2:0] A_CNT  = 3'd4;
   localparam logic [2:0] A_CAP  = 3'd5;

   localparam int CTRL_W = 9;

   typedef struct packed {
      logic       gpio_val;
      logic       gpio_dir;
      logic       ovf_ie;
      logic       cmp_ie;
      logic       inv;
      logic       en;
      logic [2:0] mode;
   } ctrl_t;
endpackage

// File: rtl/mmt_sync.sv
module mmt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("mmt_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[0], d};
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mmt_core.sv
module mmt_core
   import mmt_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [2:0]       mode,
   input  logic             lvl,
   input  logic [CNT_W-1:0] load,
   input  logic [CNT_W-1:0] cmp,
   input  logic             clr_cmp,
   input  logic             clr_ovf,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cap_q,
   output logic             flag_cmp_q,
   output logic             flag_ovf_q,
   output logic             out_q
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic             lvl_d, armed_q;
   logic [CNT_W-1:0] cnt_n, cap_n;
   logic             arm_n, out_n, set_c, set_o;
   logic             rise, fall, evt, cnt_mode, match, full;

   assign rise     = lvl & ~lvl_d;
   assign fall     = ~lvl & lvl_d;
   assign cnt_mode = (mode == M_PULSE) || (mode == M_TOGGLE) || (mode == M_EVENT);
   assign evt      = (mode == M_EVENT) ? rise : 1'b1;
   assign match    = (cnt_q == cmp);
   assign full     = &cnt_q;

   always_comb begin
      cnt_n = cnt_q;
      cap_n = cap_q;
      arm_n = armed_q;
      out_n = out_q;
      set_c = 1'b0;
      set_o = 1'b0;
      if (start) begin
         cnt_n = load;
         arm_n = 1'b0;
         out_n = 1'b0;
      end else if (run) begin
         if (cnt_mode) begin
            if (evt) begin
               if (match) begin
                  cnt_n = load;
                  set_c = 1'b1;
                  out_n = (mode == M_TOGGLE) ? ~out_q : 1'b1;
               end else begin
                  cnt_n = cnt_q + ONE;
                  set_o = full;
                  if (mode == M_PULSE) out_n = 1'b0;
               end
            end
         end else if (mode == M_WIDTH) begin
            if (rise) begin
               cnt_n = load + ONE;
               arm_n = 1'b1;
            end else if (fall && armed_q) begin
               cap_n = cnt_q;
               set_c = 1'b1;
               cnt_n = load;
               arm_n = 1'b0;
            end else if (armed_q && lvl) begin
               cnt_n = cnt_q + ONE;
               set_o = full;
            end
         end else if (mode == M_PERIOD) begin
            if (rise) begin
               if (armed_q) begin
                  cap_n = cnt_q;
                  set_c = 1'b1;
               end
               cnt_n = load + ONE;
               arm_n = 1'b1;
            end else if (armed_q) begin
               cnt_n = cnt_q + ONE;
               set_o = full;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         cap_q      <= '0;
         armed_q    <= 1'b0;
         out_q      <= 1'b0;
         lvl_d      <= 1'b0;
         flag_cmp_q <= 1'b0;
         flag_ovf_q <= 1'b0;
      end else begin
         cnt_q      <= cnt_n;
         cap_q      <= cap_n;
         armed_q    <= arm_n;
         out_q      <= out_n;
         lvl_d      <= lvl;
         flag_cmp_q <= (flag_cmp_q & ~clr_cmp) | set_c;
         flag_ovf_q <= (flag_ovf_q & ~clr_ovf) | set_o;
      end
   end

   assert_start_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> cnt_q == $past(load));
   assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !start) |=> cnt_q == $past(cnt_q));
   assert_reload_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start && cnt_mode && evt && match) |=> (cnt_q == $past(load)) && flag_cmp_q);
   assert_wrap_sets_ovf_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start && cnt_mode && evt && !match && full) |=> (cnt_q == '0) && flag_ovf_q);
   assert_width_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start && mode == M_WIDTH && armed_q && fall) |=> (cap_q == $past(cnt_q)) && flag_cmp_q);
endmodule

// File: rtl/mmt_pinmux.sv
module mmt_pinmux
   import mmt_pkg::*;
(
   input  ctrl_t ctrl,
   input  logic  out_q,
   output logic  pin_out,
   output logic  pin_oe
);
   logic gpio_like;
   assign gpio_like = (ctrl.mode == M_GPIO) || (ctrl.mode > M_PERIOD);

   always_comb begin
      pin_out = 1'b0;
      pin_oe  = 1'b0;
      if (gpio_like) begin
         pin_oe  = ctrl.gpio_dir;
         pin_out = ctrl.gpio_val ^ ctrl.inv;
      end else if (ctrl.en && (ctrl.mode == M_PULSE || ctrl.mode == M_TOGGLE)) begin
         pin_oe  = 1'b1;
         pin_out = out_q ^ ctrl.inv;
      end
   end
endmodule

// File: rtl/mmtimer.sv
module mmtimer
   import mmt_pkg::*;
#(
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              pin_in,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              irq_cmp,
   output logic              irq_ovf
);
   localparam int STAT_PAD = CNT_W - 3;

   generate
      if (CNT_W < CTRL_W) begin : g_bad_w
         $error("mmtimer: CNT_W must hold the control fields");
      end
      if (ADDR_W != 3) begin : g_bad_a
         $error("mmtimer: ADDR_W must be 3");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] load_q, cmp_q, cnt, cap;
   logic             wr_ctrl, start, clr_c, clr_o;
   logic             pin_s, lvl, flag_c, flag_o, out_q;

   assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
   assign start   = wr_ctrl && wr_data[3] && !ctrl_q.en;
   assign clr_c   = wr_en && (wr_addr == A_STAT) && wr_data[0];
   assign clr_o   = wr_en && (wr_addr == A_STAT) && wr_data[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
         cmp_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL:  ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            A_LOAD:  load_q <= wr_data;
            A_CMP:   cmp_q  <= wr_data;
            default: ;
         endcase
      end
   end

   mmt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

   assign lvl = pin_s ^ ctrl_q.inv;

   mmt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .start(start), .run(ctrl_q.en),
      .mode(ctrl_q.mode), .lvl(lvl), .load(load_q), .cmp(cmp_q),
      .clr_cmp(clr_c), .clr_ovf(clr_o), .cnt_q(cnt), .cap_q(cap),
      .flag_cmp_q(flag_c), .flag_ovf_q(flag_o), .out_q(out_q));

   mmt_pinmux u_pin (
      .ctrl(ctrl_q), .out_q(out_q), .pin_out(pin_out), .pin_oe(pin_oe));

   assign irq_cmp = flag_c & ctrl_q.cmp_ie;
   assign irq_ovf = flag_o & ctrl_q.ovf_ie;

   always_comb begin
      case (rd_addr)
         A_CTRL:  rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
         A_LOAD:  rd_data = load_q;
         A_CMP:   rd_data = cmp_q;
         A_STAT:  rd_data = {{STAT_PAD{1'b0}}, lvl, flag_o, flag_c};
         A_CNT:   rd_data = cnt;
         A_CAP:   rd_data = cap;
         default: rd_data = '0;
      endcase
   end

   assert_tristate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_q.mode >= M_PULSE) && (ctrl_q.mode <= M_PERIOD) && !ctrl_q.en) |-> !pin_oe);
   assert_input_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_q.mode == M_EVENT) || (ctrl_q.mode == M_WIDTH) || (ctrl_q.mode == M_PERIOD)) |-> !pin_oe);
   assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_c && !flag_c) |=> !flag_c || $past(ctrl_q.en));
endmodule

// File: tb/mmtimer_bench.sv
module mmtimer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [23:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [23:0] rd_data;
   logic        pin_in = 1'b0;
   logic        pin_out, pin_oe, irq_cmp, irq_ovf;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   mmtimer u_mmtimer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_cmp(irq_cmp), .irq_ovf(irq_ovf));

   // mode[3], inv[1], load[24], len[8], expected capture[24]
   localparam logic [59:0] VEC [6] = '{
      {3'd4, 1'b0, 24'd10,  8'd7,  24'd17},
      {3'd4, 1'b1, 24'd0,   8'd12, 24'd12},
      {3'd4, 1'b0, 24'd100, 8'd3,  24'd103},
      {3'd5, 1'b0, 24'd0,   8'd9,  24'd9},
      {3'd5, 1'b1, 24'd50,  8'd6,  24'd56},
      {3'd5, 1'b0, 24'd0,   8'd20, 24'd20}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [23:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [23:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [23:0] cw(input logic [2:0] mode, input logic en, input logic inv,
                                      input logic cie, input logic oie, input logic dir,
                                      input logic val);
      return {15'd0, val, dir, oie, cie, inv, en, mode};
   endfunction

   task automatic wait_cmp(output int n);
      n = 0;
      while (n < 100) begin
         @(negedge clk);
         n++;
         if (irq_cmp) break;
      end
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      logic [23:0] v, v2;
      int n;
      idle(3);
      // R12: reset state
      rd(3'd4, v); chk("R12 count", v, 0);
      rd(3'd3, v); chk("R12 status", v, 0);
      chk("R12 oe", pin_oe, 0);
      chk("R12 irq", {irq_cmp, irq_ovf}, 0);
      rst_n = 1'b1;
      idle(2);

      // R7: GPIO read and drive
      pin_in = 1'b1;
      wr(3'd0, cw(3'd0, 0, 0, 0, 0, 0, 0)); idle(3);
      rd(3'd3, v); chk("R7 read direct", v[2], 1);
      wr(3'd0, cw(3'd0, 0, 1, 0, 0, 0, 0)); idle(1);
      rd(3'd3, v); chk("R7 read inverted", v[2], 0);
      wr(3'd0, cw(3'd0, 0, 1, 0, 0, 1, 1)); idle(1);
      chk("R7 drive oe", pin_oe, 1);
      chk("R7 drive inverted", pin_out, 0);
      // R11: code 7 acts as GPIO
      wr(3'd0, cw(3'd7, 0, 0, 0, 0, 1, 1)); idle(1);
      chk("R11 oe", pin_oe, 1);
      chk("R11 out", pin_out, 1);
      pin_in = 1'b0;

      // R3/R8: pulse mode, load 0, compare 3
      wr(3'd0, cw(3'd1, 0, 0, 0, 0, 0, 0));
      chk("R9 disabled pulse oe", pin_oe, 0);
      wr(3'd1, 24'd0); wr(3'd2, 24'd3);
      wr(3'd0, cw(3'd1, 1, 0, 1, 0, 0, 0));
      wait_cmp(n);
      chk("R3 events to compare", n, 4);
      chk("R8 pulse high", pin_out, 1);
      chk("R8 pulse oe", pin_oe, 1);
      idle(1);
      chk("R8 pulse one clock", pin_out, 0);

      // R10: W1C and gating
      wr(3'd0, cw(3'd1, 0, 0, 0, 0, 0, 0));
      rd(3'd3, v); chk("R10 flag kept", v[0], 1);
      chk("R10 irq gated", irq_cmp, 0);
      wr(3'd3, 24'd2);
      rd(3'd3, v); chk("R10 write 0 keeps", v[0], 1);
      wr(3'd3, 24'd1);
      rd(3'd3, v); chk("R10 cleared", v[0], 0);

      // R3/R8: toggle mode inverted, load 5, compare 9
      wr(3'd1, 24'd5); wr(3'd2, 24'd9);
      wr(3'd0, cw(3'd2, 1, 1, 1, 0, 0, 0));
      chk("R8 toggle start level", pin_out, 1);
      wait_cmp(n);
      chk("R3 M-N+1 events", n, 5);
      chk("R8 toggled", pin_out, 0);
      // R1: stop holds
      wr(3'd0, cw(3'd2, 0, 1, 1, 0, 0, 0));
      chk("R9 disabled toggle oe", pin_oe, 0);
      rd(3'd4, v); idle(4); rd(3'd4, v2);
      chk("R1 held when off", v2, v);
      wr(3'd3, 24'd1);
      wr(3'd1, 24'd7);
      wr(3'd0, cw(3'd2, 1, 1, 0, 0, 0, 0));
      rd(3'd4, v); chk("R1 start loads", v, 7);
      wr(3'd0, cw(3'd2, 0, 1, 0, 0, 0, 0));

      // R4: event count rising, invert 0
      pin_in = 1'b0;
      wr(3'd0, cw(3'd3, 0, 0, 0, 0, 0, 0)); idle(4);
      wr(3'd1, 24'd0); wr(3'd2, 24'hFFFFFF);
      wr(3'd0, cw(3'd3, 1, 0, 0, 0, 0, 0));
      chk("R9 event mode oe", pin_oe, 0);
      for (int k = 0; k < 3; k++) begin
         pin_in = 1'b1; idle(3); pin_in = 1'b0; idle(3);
      end
      idle(3);
      rd(3'd4, v); chk("R4 rising count", v, 3);
      wr(3'd0, cw(3'd3, 0, 0, 0, 0, 0, 0));

      // R4: invert 1 counts falling only
      pin_in = 1'b1;
      wr(3'd0, cw(3'd3, 0, 1, 0, 0, 0, 0)); idle(4);
      wr(3'd0, cw(3'd3, 1, 1, 0, 0, 0, 0));
      pin_in = 1'b0; idle(4);
      rd(3'd4, v); chk("R4 falling counted", v, 1);
      pin_in = 1'b1; idle(4);
      rd(3'd4, v); chk("R4 rising ignored", v, 1);
      wr(3'd0, cw(3'd3, 0, 1, 0, 0, 0, 0));

      // R2: overflow via falling edges
      wr(3'd1, 24'hFFFFFE); wr(3'd2, 24'd5);
      wr(3'd0, cw(3'd3, 1, 1, 0, 1, 0, 0));
      for (int k = 0; k < 2; k++) begin
         pin_in = 1'b0; idle(3); pin_in = 1'b1; idle(3);
      end
      idle(2);
      rd(3'd4, v); chk("R2 wrapped", v, 0);
      chk("R2 irq_ovf", irq_ovf, 1);
      wr(3'd3, 24'd2);
      chk("R10 ovf cleared", irq_ovf, 0);
      wr(3'd0, cw(3'd3, 0, 1, 0, 0, 0, 0));

      // R5/R6: measurement vectors
      foreach (VEC[i]) begin
         logic [2:0]  m;
         logic        inv;
         logic [23:0] ld, ex;
         int          len;
         m = VEC[i][59:57]; inv = VEC[i][56]; ld = VEC[i][55:32];
         len = int'(VEC[i][31:24]); ex = VEC[i][23:0];
         pin_in = inv;
         wr(3'd0, cw(m, 0, inv, 0, 0, 0, 0)); idle(4);
         wr(3'd3, 24'd3);
         wr(3'd1, ld);
         wr(3'd0, cw(m, 1, inv, 0, 0, 0, 0));
         idle(2);
         if (m == 3'd4) begin
            pin_in = ~inv; idle(len); pin_in = inv;
         end else begin
            for (int k = 0; k < 3; k++) begin
               pin_in = ~inv; idle(2); pin_in = inv; idle(len - 2);
            end
         end
         idle(5);
         rd(3'd5, v);
         chk(m == 3'd4 ? "R5 width capture" : "R6 period capture", v, ex);
         rd(3'd3, v); chk(m == 3'd4 ? "R5 flag" : "R6 flag", v[0], 1);
         wr(3'd0, cw(m, 0, inv, 0, 0, 0, 0));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule